// File: doc/BRIEF.md
# Doorbell and Mailbox Register Unit

This block is a memory-mapped messaging unit placed between a host bus and an embedded controller. It holds four 32-bit message words (two flowing inbound to the controller, two flowing outbound to the host), an inbound and an outbound doorbell, a read-only pending view of each doorbell, and an interrupt mask for each doorbell. The host and the controller each have their own simple 32-bit register port, and each side has one interrupt line raised by the other side's doorbell.

A typical exchange runs as follows. The host stores a queue index in an inbound message word and then rings an inbound doorbell bit. The controller is interrupted, reads the word, and clears the bit by writing a one to it. Traffic in the other direction uses the same pattern through the outbound doorbell. The host acknowledges outbound events by writing the value it read back to the doorbell. A doorbell read of zero means that nothing is pending. Doorbells only hold the low event bits, so a doorbell read can never return all ones, which a host takes as a missing device.

Top module: `mbox_unit`

## Requirements
- R1: After reset, all message words and both doorbells read 0, both mask registers read 0x1F (every doorbell bit masked), and both interrupt lines are low.
- R2: The byte addresses are: inbound message 0 at 0x10, inbound message 1 at 0x14, outbound message 0 at 0x18, outbound message 1 at 0x1C, inbound doorbell at 0x20, inbound pending at 0x24, inbound mask at 0x28, outbound doorbell at 0x2C, outbound pending at 0x30, outbound mask at 0x3C. Both ports use the same addresses. An access is decoded only when the whole address matches.
- R3: The inbound doorbell holds bits [4:0]. Bit 0 is handshake, bit 1 is request head moved, bit 2 is status tail moved, bit 3 is host stopped and bit 4 is reset. A host write ORs data bits [4:0] into it. A controller write clears each bit written as one. When both happen in the same cycle, a bit that is being set ends up set.
- R4: The outbound doorbell holds bits [4:0]. Bit 0 is handshake, bit 1 is request tail moved, bit 2 is status head moved, bit 3 is bus change and bit 4 is event pending. A controller write ORs data bits into it. A host write clears exactly the bits written as one. When both happen in the same cycle, set wins.
- R5: Each interrupt line is high in the cycle after its doorbell and mask registers hold a value whose (doorbell AND NOT mask) is nonzero, and low otherwise. irq_to_ctrl follows the inbound pair and irq_to_host follows the outbound pair.
- R6: The pending registers at 0x24 and 0x30 read doorbell AND NOT mask, zero-extended. Writes to them have no effect.
- R7: Both ports can write any message word. If both write the same word in the same cycle, the host value is kept. Both ports can read every message word.
- R8: Read data is registered. It appears on the port in the cycle after a read request and holds its value until the next read. It shows register contents from before any write made in that same cycle. Unmapped or misaligned addresses read 0 and writes to them are ignored. Doorbell and pending reads have bits [31:5] at 0.
- R9: Only the controller writes the inbound mask, and only the host writes the outbound mask. A write to either mask from the other port is ignored. Each mask holds bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_en | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| c_en | input | 1 | Controller access request |
| c_we | input | 1 | Controller write (1) or read (0) |
| c_addr | input | 8 | Controller byte address |
| c_wdata | input | 32 | Controller write data |
| c_rdata | output | 32 | Controller read data, registered |
| irq_to_ctrl | output | 1 | Inbound doorbell interrupt to the controller |
| irq_to_host | output | 1 | Outbound doorbell interrupt to the host |

## Verification
The bench drives same-cycle set and clear of one doorbell bit from both ports. A design where the clear wins would lose an event, and the outbound doorbell would read 0 where 0x01 is expected. It writes to the mask and pending registers from the port that has no write access to them. A decoder that lets those writes through would change the mask or the doorbell that is read back next. It also checks the interrupt a cycle after each mask change, and reads unmapped, misaligned and idle cycles. A design with a combinational read path, or one that drives stale bits, fails the per-clock comparison of read data with the behavioural model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Byte offsets of the register file (word aligned)
  localparam int unsigned OFS_MSG_BASE = 'h10; // four contiguous message words
  localparam int unsigned OFS_IN_DB    = 'h20;
  localparam int unsigned OFS_IN_PEND  = 'h24;
  localparam int unsigned OFS_IN_MASK  = 'h28;
  localparam int unsigned OFS_OUT_DB   = 'h2C;
  localparam int unsigned OFS_OUT_PEND = 'h30;
  localparam int unsigned OFS_OUT_MASK = 'h3C;

  // Message words per direction; inbound words come first
  localparam int unsigned MSG_PER_DIR  = 2;

  // Inbound doorbell event positions
  localparam int unsigned IDB_HANDSHAKE = 0;
  localparam int unsigned IDB_REQ_HEAD  = 1;
  localparam int unsigned IDB_STS_TAIL  = 2;
  localparam int unsigned IDB_HOST_STOP = 3;
  localparam int unsigned IDB_RESET     = 4;
  // Outbound doorbell event positions
  localparam int unsigned ODB_HANDSHAKE = 0;
  localparam int unsigned ODB_REQ_TAIL  = 1;
  localparam int unsigned ODB_STS_HEAD  = 2;
  localparam int unsigned ODB_BUS_CHG   = 3;
  localparam int unsigned ODB_EVENT     = 4;
endpackage

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int DB_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [DB_W-1:0] set_i,
  input  logic [DB_W-1:0] clr_i,
  input  logic            mask_we_i,
  input  logic [DB_W-1:0] mask_d_i,
  output logic [DB_W-1:0] db_o,
  output logic [DB_W-1:0] mask_o,
  output logic            irq_o
);
  logic [DB_W-1:0] db_q;
  logic [DB_W-1:0] mask_q;
  logic            irq_q;
  logic [DB_W-1:0] pend;

  assign pend = db_q & ~mask_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      db_q   <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      db_q  <= (db_q & ~clr_i) | set_i;  // set has priority
      irq_q <= (pend != '0);
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign db_o   = db_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_set_lands_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_i != '0) |=> ((db_q & $past(set_i)) == $past(set_i)));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    ((clr_i & ~set_i) != '0) |=> ((db_q & $past(clr_i & ~set_i)) == '0));
  assert_irq_rise_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend != '0) |=> irq_o);
  assert_irq_fall_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend == '0) |=> !irq_o);
  assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/mbox_msgbank.sv
module mbox_msgbank #(
  parameter int DATA_W  = 32,
  parameter int N_WORDS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic [N_WORDS-1:0]             h_we_i,
  input  logic [N_WORDS-1:0]             c_we_i,
  input  logic [DATA_W-1:0]              h_d_i,
  input  logic [DATA_W-1:0]              c_d_i,
  output logic [N_WORDS-1:0][DATA_W-1:0] q_o
);
  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i) begin
      if (rst_i)          word_q <= '0;
      else if (h_we_i[k]) word_q <= h_d_i;   // host wins a tie
      else if (c_we_i[k]) word_q <= c_d_i;
    end
    assign q_o[k] = word_q;

    assert_host_wins_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      h_we_i[k] |=> (q_o[k] == $past(h_d_i)));
    assert_ctrl_write_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!h_we_i[k] && c_we_i[k]) |=> (q_o[k] == $past(c_d_i)));
    assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!h_we_i[k] && !c_we_i[k]) |=> $stable(q_o[k]));
  end
endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport
  import mbox_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int DB_W    = 5,
  parameter int N_WORDS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic                           en_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [N_WORDS-1:0][DATA_W-1:0] msg_i,
  input  logic [DB_W-1:0]                in_db_i,
  input  logic [DB_W-1:0]                in_mask_i,
  input  logic [DB_W-1:0]                out_db_i,
  input  logic [DB_W-1:0]                out_mask_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [DATA_W-1:0] sel;
  logic              hit;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int k = 0; k < N_WORDS; k++) begin
      if (addr_i == ADDR_W'(OFS_MSG_BASE + 4 * k)) begin
        sel = msg_i[k];
        hit = 1'b1;
      end
    end
    if (addr_i == ADDR_W'(OFS_IN_DB)) begin
      sel = DATA_W'(in_db_i); hit = 1'b1;
    end else if (addr_i == ADDR_W'(OFS_IN_PEND)) begin
      sel = DATA_W'(in_db_i & ~in_mask_i); hit = 1'b1;
    end else if (addr_i == ADDR_W'(OFS_IN_MASK)) begin
      sel = DATA_W'(in_mask_i); hit = 1'b1;
    end else if (addr_i == ADDR_W'(OFS_OUT_DB)) begin
      sel = DATA_W'(out_db_i); hit = 1'b1;
    end else if (addr_i == ADDR_W'(OFS_OUT_PEND)) begin
      sel = DATA_W'(out_db_i & ~out_mask_i); hit = 1'b1;
    end else if (addr_i == ADDR_W'(OFS_OUT_MASK)) begin
      sel = DATA_W'(out_mask_i); hit = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)              rdata_q <= '0;
    else if (en_i && !we_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;

  assert_read_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !(en_i && !we_i) |=> $stable(rdata_o));
  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !we_i && !hit) |=> (rdata_o == '0));
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DB_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_en,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              c_en,
  input  logic              c_we,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata,
  output logic              irq_to_ctrl,
  output logic              irq_to_host
);
  localparam int N_WORDS = 2 * MSG_PER_DIR;

  logic h_wr, c_wr;
  assign h_wr = h_en && h_we;
  assign c_wr = c_en && c_we;

  // Message word write decode
  logic [N_WORDS-1:0]             h_msg_we, c_msg_we;
  logic [N_WORDS-1:0][DATA_W-1:0] msg_q;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_dec
    assign h_msg_we[k] = h_wr && (h_addr == ADDR_W'(OFS_MSG_BASE + 4 * k));
    assign c_msg_we[k] = c_wr && (c_addr == ADDR_W'(OFS_MSG_BASE + 4 * k));
  end

  mbox_msgbank #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_msg (
    .clk_i  (clk),
    .rst_i  (rst),
    .h_we_i (h_msg_we),
    .c_we_i (c_msg_we),
    .h_d_i  (h_wdata),
    .c_d_i  (c_wdata),
    .q_o    (msg_q)
  );

  // Inbound doorbell: host sets, controller clears and masks
  logic [DB_W-1:0] in_set, in_clr, in_db, in_mask;
  logic            in_mask_we;
  assign in_set     = (h_wr && h_addr == ADDR_W'(OFS_IN_DB)) ? h_wdata[DB_W-1:0] : '0;
  assign in_clr     = (c_wr && c_addr == ADDR_W'(OFS_IN_DB)) ? c_wdata[DB_W-1:0] : '0;
  assign in_mask_we = c_wr && (c_addr == ADDR_W'(OFS_IN_MASK));

  mbox_doorbell #(.DB_W(DB_W)) u_in_db (
    .clk_i     (clk),
    .rst_i     (rst),
    .set_i     (in_set),
    .clr_i     (in_clr),
    .mask_we_i (in_mask_we),
    .mask_d_i  (c_wdata[DB_W-1:0]),
    .db_o      (in_db),
    .mask_o    (in_mask),
    .irq_o     (irq_to_ctrl)
  );

  // Outbound doorbell: controller sets, host clears and masks
  logic [DB_W-1:0] out_set, out_clr, out_db, out_mask;
  logic            out_mask_we;
  assign out_set     = (c_wr && c_addr == ADDR_W'(OFS_OUT_DB)) ? c_wdata[DB_W-1:0] : '0;
  assign out_clr     = (h_wr && h_addr == ADDR_W'(OFS_OUT_DB)) ? h_wdata[DB_W-1:0] : '0;
  assign out_mask_we = h_wr && (h_addr == ADDR_W'(OFS_OUT_MASK));

  mbox_doorbell #(.DB_W(DB_W)) u_out_db (
    .clk_i     (clk),
    .rst_i     (rst),
    .set_i     (out_set),
    .clr_i     (out_clr),
    .mask_we_i (out_mask_we),
    .mask_d_i  (h_wdata[DB_W-1:0]),
    .db_o      (out_db),
    .mask_o    (out_mask),
    .irq_o     (irq_to_host)
  );

  mbox_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DB_W(DB_W), .N_WORDS(N_WORDS)) u_h_rd (
    .clk_i      (clk),
    .rst_i      (rst),
    .en_i       (h_en),
    .we_i       (h_we),
    .addr_i     (h_addr),
    .msg_i      (msg_q),
    .in_db_i    (in_db),
    .in_mask_i  (in_mask),
    .out_db_i   (out_db),
    .out_mask_i (out_mask),
    .rdata_o    (h_rdata)
  );

  mbox_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DB_W(DB_W), .N_WORDS(N_WORDS)) u_c_rd (
    .clk_i      (clk),
    .rst_i      (rst),
    .en_i       (c_en),
    .we_i       (c_we),
    .addr_i     (c_addr),
    .msg_i      (msg_q),
    .in_db_i    (in_db),
    .in_mask_i  (in_mask),
    .out_db_i   (out_db),
    .out_mask_i (out_mask),
    .rdata_o    (c_rdata)
  );

  assert_in_mask_owner_R9: assert property (@(posedge clk) disable iff (rst)
    !(c_wr && c_addr == ADDR_W'(OFS_IN_MASK)) |=> $stable(in_mask));
  assert_out_mask_owner_R9: assert property (@(posedge clk) disable iff (rst)
    !(h_wr && h_addr == ADDR_W'(OFS_OUT_MASK)) |=> $stable(out_mask));
  assert_host_db_upper_R8: assert property (@(posedge clk) disable iff (rst)
    (h_en && !h_we && (h_addr == ADDR_W'(OFS_OUT_DB) || h_addr == ADDR_W'(OFS_IN_DB)))
      |=> (h_rdata[DATA_W-1:DB_W] == '0));
endmodule

// File: tb/mbox_unit_bench.sv
`timescale 1ns/1ps
module mbox_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_en = 1'b0, h_we = 1'b0, c_en = 1'b0, c_we = 1'b0;
  logic [7:0]  h_addr = '0, c_addr = '0;
  logic [31:0] h_wdata = '0, c_wdata = '0;
  logic [31:0] h_rdata, c_rdata;
  logic        irq_to_ctrl, irq_to_host;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  mbox_unit u_mbox_unit (
    .clk(clk), .rst(rst),
    .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_en(c_en), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .irq_to_ctrl(irq_to_ctrl), .irq_to_host(irq_to_host)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_msg [4];
  logic [4:0]  m_idb, m_imask, m_odb, m_omask;
  logic [31:0] m_hr, m_cr;
  logic        m_irqc, m_irqh;

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h10: return m_msg[0];
      8'h14: return m_msg[1];
      8'h18: return m_msg[2];
      8'h1C: return m_msg[3];
      8'h20: return {27'd0, m_idb};
      8'h24: return {27'd0, m_idb & ~m_imask};
      8'h28: return {27'd0, m_imask};
      8'h2C: return {27'd0, m_odb};
      8'h30: return {27'd0, m_odb & ~m_omask};
      8'h3C: return {27'd0, m_omask};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic hw, cw;
    logic [4:0] iset, iclr, oset, oclr;
    if (rst) begin
      for (int i = 0; i < 4; i++) m_msg[i] <= '0;
      m_idb <= '0; m_odb <= '0; m_imask <= 5'h1F; m_omask <= 5'h1F;
      m_hr <= '0; m_cr <= '0; m_irqc <= 1'b0; m_irqh <= 1'b0;
    end else begin
      hw = h_en && h_we;
      cw = c_en && c_we;
      if (h_en && !h_we) m_hr <= mread(h_addr);
      if (c_en && !c_we) m_cr <= mread(c_addr);
      m_irqc <= ((m_idb & ~m_imask) != 0);
      m_irqh <= ((m_odb & ~m_omask) != 0);
      iset = (hw && h_addr == 8'h20) ? h_wdata[4:0] : 5'd0;
      iclr = (cw && c_addr == 8'h20) ? c_wdata[4:0] : 5'd0;
      oset = (cw && c_addr == 8'h2C) ? c_wdata[4:0] : 5'd0;
      oclr = (hw && h_addr == 8'h2C) ? h_wdata[4:0] : 5'd0;
      m_idb <= (m_idb & ~iclr) | iset;
      m_odb <= (m_odb & ~oclr) | oset;
      if (cw && c_addr == 8'h28) m_imask <= c_wdata[4:0];
      if (hw && h_addr == 8'h3C) m_omask <= h_wdata[4:0];
      for (int i = 0; i < 4; i++) begin
        if (cw && c_addr == 8'(8'h10 + 4 * i)) m_msg[i] <= c_wdata;
        if (hw && h_addr == 8'(8'h10 + 4 * i)) m_msg[i] <= h_wdata; // host last: wins
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R5, R8)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R8 host rdata vs model", h_rdata, m_hr);
      check("R8 ctrl rdata vs model", c_rdata, m_cr);
      check("R5 irq_to_ctrl vs model", {31'd0, irq_to_ctrl}, {31'd0, m_irqc});
      check("R5 irq_to_host vs model", {31'd0, irq_to_host}, {31'd0, m_irqh});
    end
  end

  // ---------------- stimulus helpers (called just after a negedge) ----------------
  task automatic op(input logic hen, input logic hwe, input logic [7:0] ha, input logic [31:0] hd,
                    input logic cen, input logic cwe, input logic [7:0] ca, input logic [31:0] cd);
    h_en = hen; h_we = hwe; h_addr = ha; h_wdata = hd;
    c_en = cen; c_we = cwe; c_addr = ca; c_wdata = cd;
    @(negedge clk);
    h_en = 1'b0; h_we = 1'b0; c_en = 1'b0; c_we = 1'b0;
  endtask
  task automatic hwr(input logic [7:0] a, input logic [31:0] d); op(1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic cwr(input logic [7:0] a, input logic [31:0] d); op(0, 0, 0, 0, 1, 1, a, d); endtask
  task automatic hrd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    op(1, 0, a, 0, 0, 0, 0, 0); check(tag, h_rdata, exp);
  endtask
  task automatic crd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    op(0, 0, 0, 0, 1, 0, a, 0); check(tag, c_rdata, exp);
  endtask
  task automatic idle(); op(0, 0, 0, 0, 0, 0, 0, 0); endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    case (r % 12)
      0: return 8'h10;  1: return 8'h14;  2: return 8'h18;  3: return 8'h1C;
      4: return 8'h20;  5: return 8'h24;  6: return 8'h28;  7: return 8'h2C;
      8: return 8'h30;  9: return 8'h3C; 10: return 8'h40;
      default: return 8'h13;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle();
    check("R1 irq_to_ctrl after reset", {31'd0, irq_to_ctrl}, 32'd0);
    check("R1 irq_to_host after reset", {31'd0, irq_to_host}, 32'd0);
    hrd(8'h28, 32'h1F, "R1 inbound mask reset");
    hrd(8'h3C, 32'h1F, "R1 outbound mask reset");
    hrd(8'h10, 32'h0,  "R1 message reset");
    crd(8'h2C, 32'h0,  "R1 outbound doorbell reset");

    // message words across ports
    hwr(8'h10, 32'h0000_0007);
    crd(8'h10, 32'h0000_0007, "R2 R7 inbound msg0 seen by controller");
    cwr(8'h1C, 32'hCAFE_0001);
    hrd(8'h1C, 32'hCAFE_0001, "R2 R7 outbound msg1 seen by host");

    // inbound doorbell OR-set, masked interrupt, unmask, clear
    hwr(8'h20, 32'h2);
    hwr(8'h20, 32'h1);
    crd(8'h20, 32'h3, "R3 host writes OR into inbound doorbell");
    check("R5 masked inbound gives no irq", {31'd0, irq_to_ctrl}, 32'd0);
    crd(8'h24, 32'h0, "R6 inbound pending fully masked");
    cwr(8'h28, 32'h1D);
    crd(8'h24, 32'h2, "R6 inbound pending after unmask");
    check("R5 irq_to_ctrl rises after unmask", {31'd0, irq_to_ctrl}, 32'd1);
    cwr(8'h20, 32'h2);
    crd(8'h20, 32'h1, "R3 controller write-one clears");
    check("R5 irq_to_ctrl falls after clear", {31'd0, irq_to_ctrl}, 32'd0);
    hwr(8'h28, 32'h0);
    crd(8'h28, 32'h1D, "R9 host write to inbound mask ignored");

    // outbound doorbell
    cwr(8'h2C, 32'h14);
    hrd(8'h2C, 32'h14, "R4 controller sets outbound bits");
    hwr(8'h2C, 32'h04);
    hrd(8'h2C, 32'h10, "R4 host clears only written bits");
    hwr(8'h3C, 32'h0F);
    hrd(8'h30, 32'h10, "R6 outbound pending");
    check("R5 irq_to_host rises", {31'd0, irq_to_host}, 32'd1);
    cwr(8'h3C, 32'h1F);
    hrd(8'h3C, 32'h0F, "R9 controller write to outbound mask ignored");
    hwr(8'h2C, 32'hFFFF_FFFF);
    hrd(8'h2C, 32'h0, "R4 R8 write-back clears, idle reads zero");
    check("R5 irq_to_host falls", {31'd0, irq_to_host}, 32'd0);

    // same-cycle collisions
    op(1, 1, 8'h2C, 32'h1, 1, 1, 8'h2C, 32'h1);
    hrd(8'h2C, 32'h1, "R4 set wins over same-cycle clear");
    op(1, 1, 8'h20, 32'h8, 1, 1, 8'h20, 32'h9);
    crd(8'h20, 32'h8, "R3 set wins over same-cycle clear");
    op(1, 1, 8'h14, 32'hAAAA_0000, 1, 1, 8'h14, 32'h5555_FFFF);
    crd(8'h14, 32'hAAAA_0000, "R7 host wins same-word write");

    // writes to pending registers and unmapped space
    hwr(8'h30, 32'hFFFF_FFFF);
    hrd(8'h2C, 32'h1, "R6 write to outbound pending ignored");
    hwr(8'h24, 32'h1F);
    crd(8'h20, 32'h8, "R6 write to inbound pending ignored");
    hwr(8'h40, 32'h1234_5678);
    hrd(8'h40, 32'h0, "R8 unmapped reads zero");
    hwr(8'h11, 32'h1234_5678);
    hrd(8'h11, 32'h0, "R8 misaligned reads zero");
    hrd(8'h14, 32'hAAAA_0000, "R8 misaligned write ignored");
    idle();
    check("R8 rdata holds on idle", h_rdata, 32'hAAAA_0000);
    hwr(8'h2C, 32'h0);
    check("R8 rdata holds on write", h_rdata, 32'hAAAA_0000);

    // random traffic, compared against the model every clock
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom;
      op(r[0], r[1], pick_addr($urandom), $urandom,
         r[2], r[3], pick_addr($urandom), (r[4] ? $urandom : {27'd0, r[9:5]}));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule